// File: doc/BRIEF.md
# Banked Program Counter

This unit produces the instruction fetch address for a small 8-bit controller core whose 4 KB program space is split into two 2 KB banks. The low bank covers addresses 000h to 7FFh and the high bank covers 800h to FFFh. Ordinary fetch steps through the current bank. Taken jumps and calls supply an 11-bit in-bank target, and the unit adds the top address bit itself from a pending bank choice. Returns restore a full 12-bit address.

The decoder watches every fetched opcode that carries a valid strobe. Two opcodes choose the bank that the next jump or call will enter. The choice is only armed when the opcode is seen, and the fetch address does not move to the other bank at that point. A third opcode turns on a feature-enable output, and that output stays on until reset. The core's sequencer tells the unit, one cycle at a time, whether to advance, jump or call, return, or hold.

The reset input is asynchronous and active low. Its release passes through a synchronizer inside the unit, so the unit leaves reset two clock edges after the pin goes high.

Top module: `pc_bank_unit`

## Requirements
- R1: While reset is held, and after it is released, `fetch_addr` is 000h, `feat_en` is 0 and the pending bank is 0, so the first jump lands in the low bank.
- R2: A valid opcode 63h arms the low bank. `fetch_addr[11]` is not changed by the opcode itself, and the next jump or call clears it.
- R3: A valid opcode 73h arms the high bank. `fetch_addr[11]` is not changed by the opcode itself, and the next jump or call sets it.
- R4: A valid opcode 33h sets `feat_en` one cycle later. It then stays 1 whatever the inputs do, and only reset clears it.
- R5: A taken jump or call loads `fetch_addr` with {pending bank, `jmp_target`} one cycle later. The pending bank is kept, so later jumps enter the same bank.
- R6: When `fetch_adv` is the highest request, bits 10:0 of `fetch_addr` increment and bit 11 holds. The address therefore wraps 7FFh to 000h and FFFh to 800h.
- R7: `ret_take` loads all 12 bits of `fetch_addr` from `ret_addr` one cycle later, and the pending bank has no effect on it.
- R8: Priority is return, then jump or call, then advance. With no request the address holds.
- R9: When several bank-select opcodes arrive before a jump, only the last one counts.
- R10: An opcode with `op_valid` low, and any opcode other than 63h, 73h and 33h, changes neither the pending bank nor `feat_en`.
- R11: A bank-select opcode in the same cycle as a taken jump does not affect that jump. It applies from the next jump onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode strobe |
| opcode | input | 8 | Fetched opcode |
| jump_take | input | 1 | Taken jump this cycle |
| call_take | input | 1 | Taken call this cycle |
| jmp_target | input | 11 | In-bank target of the jump or call |
| ret_take | input | 1 | Return this cycle |
| ret_addr | input | 12 | Full return address |
| fetch_adv | input | 1 | Sequential advance request |
| fetch_addr | output | 12 | Current fetch address |
| feat_en | output | 1 | Sticky feature enable |

## Verification
The pending bank bit is not visible at the ports until a jump or call is taken. If it is corrupted, nothing shows until the next jump or call, which then lands on the wrong side of 800h in the cycle after it is taken. The bench therefore follows bank selections with jumps, both at once and after long runs of unrelated traffic. A bad increment or a wrong request priority shows in `fetch_addr` one cycle after the request. A flag that clears on its own shows on `feat_en` in the first cycle that it drops.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam logic [7:0] OP_BANK_LO = 8'h63;
  localparam logic [7:0] OP_BANK_HI = 8'h73;
  localparam logic [7:0] OP_FEAT_ON = 8'h33;

  typedef enum logic [1:0] {
    PC_HOLD,
    PC_STEP,
    PC_LOAD_JMP,
    PC_LOAD_RET
  } pc_act_e;
endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
(
  input  logic       op_valid,
  input  logic [7:0] opcode,
  output logic       sel_lo,
  output logic       sel_hi,
  output logic       feat_set
);
  always_comb begin
    sel_lo   = op_valid && (opcode == OP_BANK_LO);
    sel_hi   = op_valid && (opcode == OP_BANK_HI);
    feat_set = op_valid && (opcode == OP_FEAT_ON);
  end
endmodule

// File: rtl/pcb_bank_state.sv
module pcb_bank_state (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_lo,
  input  logic sel_hi,
  input  logic feat_set,
  output logic bank_pend,
  output logic feat_en
);
  logic pend_q, pend_d;
  logic feat_q, feat_d;

  always_comb begin
    pend_d = pend_q;
    if (sel_hi)      pend_d = 1'b1;
    else if (sel_lo) pend_d = 1'b0;
    feat_d = feat_q | feat_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      feat_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      feat_q <= feat_d;
    end
  end

  assign bank_pend = pend_q;
  assign feat_en   = feat_q;
endmodule

// File: rtl/pcb_counter.sv
module pcb_counter
  import pcb_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int OFF_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_act_e           act,
  input  logic              bank_pend,
  input  logic [OFF_W-1:0]  jmp_target,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [ADDR_W-1:0] pc
);
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              pc_en;

  always_comb begin
    pc_en = (act != PC_HOLD);
    pc_d  = pc_q;
    unique case (act)
      PC_STEP:     pc_d = {pc_q[ADDR_W-1], pc_q[OFF_W-1:0] + OFF_W'(1)};
      PC_LOAD_JMP: pc_d = {bank_pend, jmp_target};
      PC_LOAD_RET: pc_d = ret_addr;
      default:     pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/pc_bank_unit.sv
module pc_bank_unit
  import pcb_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int OP_W        = 8,
  parameter int SYNC_STAGES = 2,
  localparam int OFF_W      = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic              jump_take,
  input  logic              call_take,
  input  logic [OFF_W-1:0]  jmp_target,
  input  logic              ret_take,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic              fetch_adv,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              feat_en
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;
  logic                   sel_lo, sel_hi, feat_set;
  logic                   bank_pend;
  pc_act_e                act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  always_comb begin
    if (ret_take)                    act = PC_LOAD_RET;
    else if (jump_take || call_take) act = PC_LOAD_JMP;
    else if (fetch_adv)              act = PC_STEP;
    else                             act = PC_HOLD;
  end

  pcb_decode i_decode (
    .op_valid (op_valid),
    .opcode   (opcode),
    .sel_lo   (sel_lo),
    .sel_hi   (sel_hi),
    .feat_set (feat_set)
  );

  pcb_bank_state i_bank (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .sel_lo    (sel_lo),
    .sel_hi    (sel_hi),
    .feat_set  (feat_set),
    .bank_pend (bank_pend),
    .feat_en   (feat_en)
  );

  pcb_counter #(.ADDR_W(ADDR_W)) i_counter (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .act        (act),
    .bank_pend  (bank_pend),
    .jmp_target (jmp_target),
    .ret_addr   (ret_addr),
    .pc         (fetch_addr)
  );
endmodule

// File: rtl/pcb_chk.sv
module pcb_chk #(
  parameter int ADDR_W = 12,
  localparam int OFF_W = ADDR_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [7:0]        opcode,
  input logic              jump_take,
  input logic              call_take,
  input logic [OFF_W-1:0]  jmp_target,
  input logic              ret_take,
  input logic [ADDR_W-1:0] ret_addr,
  input logic              fetch_adv,
  input logic              bank_pend,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              feat_en
);
  // R7
  ret_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_take |=> fetch_addr == $past(ret_addr));

  // R5
  jmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_take && (jump_take || call_take)) |=>
      fetch_addr == {$past(bank_pend), $past(jmp_target)});

  // R6
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_take && !jump_take && !call_take && fetch_adv) |=>
      (fetch_addr[OFF_W-1:0] == $past(fetch_addr[OFF_W-1:0]) + OFF_W'(1)) &&
      (fetch_addr[ADDR_W-1] == $past(fetch_addr[ADDR_W-1])));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_take && !jump_take && !call_take && !fetch_adv) |=> $stable(fetch_addr));

  // R4
  feat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feat_en |=> feat_en);

  // R3
  sel_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 8'h73) |=> bank_pend);

  // R2
  sel_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 8'h63) |=> !bank_pend);

  // R10
  no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid) |=> $stable(bank_pend));
endmodule

bind pc_bank_unit pcb_chk #(.ADDR_W(ADDR_W)) i_pcb_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .op_valid   (op_valid),
  .opcode     (opcode),
  .jump_take  (jump_take),
  .call_take  (call_take),
  .jmp_target (jmp_target),
  .ret_take   (ret_take),
  .ret_addr   (ret_addr),
  .fetch_adv  (fetch_adv),
  .bank_pend  (bank_pend),
  .fetch_addr (fetch_addr),
  .feat_en    (feat_en)
);

// File: tb/test_pc_bank_unit.sv
module test_pc_bank_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic [7:0]    opcode;
  logic          jump_take, call_take, ret_take, fetch_adv;
  logic [AW-2:0] jmp_target;
  logic [AW-1:0] ret_addr;
  logic [AW-1:0] fetch_addr;
  logic          feat_en;

  int errors = 0;
  int checks = 0;
  logic [AW-1:0] m_pc;
  logic          m_pend, m_feat;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_bank_unit i_pc_bank_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .jump_take(jump_take), .call_take(call_take), .jmp_target(jmp_target),
    .ret_take(ret_take), .ret_addr(ret_addr), .fetch_adv(fetch_adv),
    .fetch_addr(fetch_addr), .feat_en(feat_en)
  );

  function automatic logic [AW-1:0] exp_pc(logic [AW-1:0] pc, logic pend,
      logic r, logic j, logic c, logic a, logic [AW-2:0] tgt, logic [AW-1:0] ra);
    if (r)           return ra;
    else if (j || c) return {pend, tgt};
    else if (a)      return {pc[AW-1], pc[AW-2:0] + 11'd1};
    else             return pc;
  endfunction

  function automatic logic exp_pend(logic pend, logic v, logic [7:0] op);
    if (v && op == 8'h73) return 1'b1;
    if (v && op == 8'h63) return 1'b0;
    return pend;
  endfunction

  task automatic chk(string tag, logic [AW-1:0] exp_a, logic exp_f);
    checks++;
    if (fetch_addr !== exp_a) begin
      errors++;
      $display("FAIL %s fetch_addr actual=%h expected=%h", tag, fetch_addr, exp_a);
    end
    checks++;
    if (feat_en !== exp_f) begin
      errors++;
      $display("FAIL %s feat_en actual=%b expected=%b", tag, feat_en, exp_f);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; opcode = 0; jump_take = 0; call_take = 0;
    ret_take = 0; fetch_adv = 0; jmp_target = 0; ret_addr = 0;
  endtask

  // Called at a falling edge; drives one cycle and checks after the next rise.
  task automatic cyc(string tag, logic v, logic [7:0] op, logic j, logic c,
      logic [AW-2:0] tgt, logic r, logic [AW-1:0] ra, logic a);
    op_valid = v; opcode = op; jump_take = j; call_take = c;
    jmp_target = tgt; ret_take = r; ret_addr = ra; fetch_adv = a;
    m_pc   = exp_pc(m_pc, m_pend, r, j, c, a, tgt, ra);
    m_pend = exp_pend(m_pend, v, op);
    m_feat = m_feat | (v && op == 8'h33);
    @(posedge clk);
    @(negedge clk);
    chk(tag, m_pc, m_feat);
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    m_pc = 0; m_pend = 0; m_feat = 0;
    repeat (2) @(negedge clk);
    chk("R1", 12'h000, 1'b0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1", 12'h000, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R1: first jump after reset lands in the low bank
    cyc("R1", 0, 8'h00, 1, 0, 11'h155, 0, 0, 0);
    // R3: select high bank, no immediate move; then advance stays low
    cyc("R3", 1, 8'h73, 0, 0, 0, 0, 0, 0);
    cyc("R3", 0, 8'h00, 0, 0, 0, 0, 0, 1);
    cyc("R3", 0, 8'h00, 0, 1, 11'h7FF, 0, 0, 0);   // call -> FFF
    cyc("R6", 0, 8'h00, 0, 0, 0, 0, 0, 1);         // FFF -> 800
    cyc("R5", 0, 8'h00, 1, 0, 11'h010, 0, 0, 0);   // bank kept -> 810
    // R2: select low bank, jump to 7FF, wrap to 000
    cyc("R2", 1, 8'h63, 0, 0, 0, 0, 0, 1);
    cyc("R2", 0, 8'h00, 1, 0, 11'h7FF, 0, 0, 0);
    cyc("R6", 0, 8'h00, 0, 0, 0, 0, 0, 1);
    // R9: last selection wins
    cyc("R9", 1, 8'h63, 0, 0, 0, 0, 0, 0);
    cyc("R9", 1, 8'h73, 0, 0, 0, 0, 0, 0);
    cyc("R9", 0, 8'h00, 1, 0, 11'h022, 0, 0, 0);
    // R10: invalid strobe and foreign opcode ignored
    cyc("R10", 0, 8'h63, 0, 0, 0, 0, 0, 0);
    cyc("R10", 0, 8'h33, 0, 0, 0, 0, 0, 0);
    cyc("R10", 1, 8'h64, 0, 0, 0, 0, 0, 0);
    cyc("R10", 0, 8'h00, 1, 0, 11'h001, 0, 0, 0);  // still high bank
    // R11: select in same cycle as jump affects only the next jump
    cyc("R11", 1, 8'h63, 1, 0, 11'h100, 0, 0, 0);  // -> 900
    cyc("R11", 0, 8'h00, 1, 0, 11'h100, 0, 0, 0);  // -> 100
    // R7: return ignores the pending bank
    cyc("R7", 0, 8'h00, 0, 0, 0, 1, 12'hA5C, 0);
    // R8: all requests at once, return wins; then jump beats advance
    cyc("R8", 0, 8'h00, 1, 1, 11'h3FF, 1, 12'h456, 1);
    cyc("R8", 0, 8'h00, 1, 0, 11'h3FF, 0, 0, 1);
    cyc("R8", 0, 8'h00, 0, 0, 0, 0, 0, 0);
    // R4: feature flag sets and sticks
    cyc("R4", 1, 8'h33, 0, 0, 0, 0, 0, 0);
    cyc("R4", 1, 8'h63, 0, 0, 0, 0, 0, 1);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      automatic int pick = int'($urandom_range(0, 9));
      automatic logic v = $urandom_range(0, 1) == 1;
      automatic logic [7:0] op = (pick < 3) ? 8'h63 : (pick < 6) ? 8'h73 :
                                 (pick < 7) ? 8'h33 : 8'($urandom);
      automatic int kind = int'($urandom_range(0, 9));
      automatic logic r = (kind == 0);
      automatic logic j = (kind == 1) || (kind == 2);
      automatic logic c = (kind == 3);
      automatic logic a = (kind >= 3) && (kind <= 8);
      automatic string tag = r ? "R7" : (j || c) ? "R5" : a ? "R6" : "R8";
      cyc(tag, v, op, j, c, 11'($urandom), r, 12'($urandom), a);
    end
    // R4: only reset clears the flag
    do_reset();
    cyc("R4", 0, 8'h33, 0, 0, 0, 0, 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule